// File: doc/BRIEF.md
# Regulator Soft-Start and Protection Sequencer

This block sequences start-up and fault recovery for a dual-output step-down switching regulator. When the enable input rises, it holds the power stage in reset for a fixed number of clocks. It then raises a digital reference code from zero, one code per programmable step interval, until the code reaches the target picked by the core-voltage select input. After that it holds the code there. A later change on the select input slews the code, one step per interval, between the reduced and the nominal core level.

While the stage runs, the block watches three kinds of fault. A per-cycle peak-current flag only cuts the present on-time short, through a one-clock terminate pulse. The block issues at most one such pulse per switching cycle. An undervoltage flag on any output is treated as a short circuit: the block returns to reset and reruns the whole ramp. The ramp and slew phases are exempt, because the outputs are expected to sit low then. An over-temperature flag forces reset and keeps it held until a separate cool-down flag reports that the hysteresis is met. Thermal ranks above short circuit, and short circuit ranks above current limit.

Top module: `softstart_seq`

## Requirements
- R1: After reset, and whenever the enable input is low, `core_rst_o` is 1, `ref_o` is 0 and `term_o` is 0.
- R2: After `en_i` rises, `core_rst_o` stays 1 for exactly RST_CYCLES+1 clock edges, then goes to 0 with `ref_o` at 0.
- R3: During a ramp, `ref_o` rises by exactly 1 every STEP_DIV clocks. It reaches the target after target×STEP_DIV clocks and then holds at the target.
- R4: The target is NOM_CODE when `vsel_i` is 1 and RED_CODE when `vsel_i` is 0. A change of `vsel_i` while running moves `ref_o` one code per STEP_DIV clocks toward the new target and stops on it.
- R5: An undervoltage flag (any bit of `uv_i`, one bit per output) raised while `ref_o` equals the target drives `core_rst_o` to 1 and `ref_o` to 0 on the next edge. The R2 and R3 sequence then repeats.
- R6: Undervoltage flags have no effect during the start-up ramp or a select slew.
- R7: `ilim_i` high while running gives a one-clock `term_o` pulse, at most one per switching cycle; `cycle_start_i` marks a new cycle. Neither `core_rst_o` nor `ref_o` changes because of it.
- R8: `ot_i` high forces `core_rst_o` to 1 on the next edge. Reset stays held after `ot_i` drops, until `cool_i` is 1 with `ot_i` 0; the R2 sequence then follows.
- R9: Priority is thermal, then short circuit, then current limit. A cycle with `ot_i` high gives no `term_o`, and the block then waits for `cool_i`, not for the plain reset count.
- R10: `en_i` low overrides everything: on the next edge `core_rst_o` is 1 and `ref_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable |
| vsel_i | input | 1 | Core level select: 1 nominal, 0 reduced |
| cycle_start_i | input | 1 | One-clock strobe at each switching-cycle start |
| ilim_i | input | 1 | Peak current-limit flag |
| uv_i | input | NOUT | Per-output undervoltage (short-circuit) flags |
| ot_i | input | 1 | Over-temperature flag |
| cool_i | input | 1 | Cool-down hysteresis satisfied |
| core_rst_o | output | 1 | Power-stage reset |
| ref_o | output | CODE_W | Reference code to the DAC |
| term_o | output | 1 | Duty-cycle terminate pulse |

## Verification
A wrong sequencer state shows on `core_rst_o` within one clock. An exit from the fault hold without the cool-down flag, for example, lowers reset after RST_CYCLES+1 edges where it should have stayed high. A fault in the step timer or the reference register shifts `ref_o` away from the arithmetic schedule start±k at clock k×STEP_DIV. That error can be seen at the first step after the fault, so at most STEP_DIV clocks later. A stuck arm bit in the terminate gate shows as a missing or repeated `term_o` within the same switching cycle.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_RESET = 3'd1,
    SQ_RAMP  = 3'd2,
    SQ_RUN   = 3'd3,
    SQ_FAULT = 3'd4
  } sq_state_t;
endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] cnt_q, cnt_n;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (!run_i)      cnt_n = '0;
    else if (tick_o) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ss_ref_slew.sv
module ss_ref_slew #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic [CODE_W-1:0] ref_o
);
  logic [CODE_W-1:0] ref_q, ref_n;
  logic              upd;

  assign upd = clr_i || step_i;

  always_comb begin
    ref_n = ref_q;
    if (clr_i)               ref_n = '0;
    else if (ref_q < tgt_i)  ref_n = ref_q + 1'b1;
    else if (ref_q > tgt_i)  ref_n = ref_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ref_q <= '0;
    else if (upd) ref_q <= ref_n;
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/ss_term_gate.sv
module ss_term_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ilim_i,
  input  logic cycle_start_i,
  input  logic allow_i,
  output logic term_o
);
  logic arm_q, arm_n;

  assign term_o = ilim_i && allow_i && (arm_q || cycle_start_i);

  always_comb begin
    arm_n = arm_q;
    if (term_o)             arm_n = 1'b0;
    else if (cycle_start_i) arm_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b1;
    else        arm_q <= arm_n;
  end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int NOM_CODE   = 120,
  parameter int RED_CODE   = 100,
  parameter int STEP_DIV   = 4,
  parameter int RST_CYCLES = 4,
  parameter int NOUT       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              vsel_i,
  input  logic              cycle_start_i,
  input  logic              ilim_i,
  input  logic [NOUT-1:0]   uv_i,
  input  logic              ot_i,
  input  logic              cool_i,
  output logic              core_rst_o,
  output logic [CODE_W-1:0] ref_o,
  output logic              term_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [RW-1:0]     RST_LAST = RW'(RST_CYCLES - 1);
  localparam logic [CODE_W-1:0] NOM_C    = CODE_W'(NOM_CODE);
  localparam logic [CODE_W-1:0] RED_C    = CODE_W'(RED_CODE);

  sq_state_t         state_q, state_n;
  logic [RW-1:0]     rcnt_q, rcnt_n;
  logic [CODE_W-1:0] tgt, ref_q;
  logic              at_tgt, active_q, active_n, uv_hit, tick, allow;

  assign tgt      = vsel_i ? NOM_C : RED_C;
  assign at_tgt   = (ref_q == tgt);
  assign active_q = (state_q == SQ_RAMP) || (state_q == SQ_RUN);
  assign active_n = (state_n == SQ_RAMP) || (state_n == SQ_RUN);
  // short-circuit flags count only once the reference has settled
  assign uv_hit   = (|uv_i) && (state_q == SQ_RUN) && at_tgt;
  assign allow    = active_q && en_i && !ot_i && !uv_hit;

  always_comb begin
    state_n = state_q;
    if (!en_i) begin
      state_n = SQ_OFF;
    end else begin
      case (state_q)
        SQ_OFF:   state_n = SQ_RESET;
        SQ_RESET: if (ot_i) state_n = SQ_FAULT;
                  else if (rcnt_q == RST_LAST) state_n = SQ_RAMP;
        SQ_RAMP:  if (ot_i) state_n = SQ_FAULT;
                  else if (at_tgt) state_n = SQ_RUN;
        SQ_RUN:   if (ot_i) state_n = SQ_FAULT;
                  else if (uv_hit) state_n = SQ_RESET;
        SQ_FAULT: if (cool_i && !ot_i) state_n = SQ_RESET;
        default:  state_n = SQ_OFF;
      endcase
    end
  end

  always_comb begin
    rcnt_n = '0;
    if ((state_q == SQ_RESET) && (state_n == SQ_RESET)) rcnt_n = rcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      rcnt_q  <= rcnt_n;
    end
  end

  ss_step_timer #(.DIV(STEP_DIV)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (active_q && active_n && !at_tgt),
    .tick_o (tick)
  );

  ss_ref_slew #(.CODE_W(CODE_W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!active_n),
    .step_i (tick),
    .tgt_i  (tgt),
    .ref_o  (ref_q)
  );

  ss_term_gate u_term (
    .clk           (clk),
    .rst_n         (rst_n),
    .ilim_i        (ilim_i),
    .cycle_start_i (cycle_start_i),
    .allow_i       (allow),
    .term_o        (term_o)
  );

  assign core_rst_o = !active_q;
  assign ref_o      = ref_q;
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int CODE_W   = 8,
  parameter int NOM_CODE = 120,
  parameter int RED_CODE = 100,
  parameter int NOUT     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              vsel_i,
  input logic              cycle_start_i,
  input logic              ilim_i,
  input logic [NOUT-1:0]   uv_i,
  input logic              ot_i,
  input logic              cool_i,
  input logic              core_rst_o,
  input logic [CODE_W-1:0] ref_o,
  input logic              term_o
);
  localparam int MAXC = (NOM_CODE > RED_CODE) ? NOM_CODE : RED_CODE;

  // R1
  rst_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (ref_o == '0 && !term_o));

  // R3
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_o && $past(!core_rst_o)) |->
      (ref_o == $past(ref_o) || ref_o == $past(ref_o) + 1'b1 || ref_o + 1'b1 == $past(ref_o)));

  // R4
  ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ref_o) <= MAXC);

  // R7
  term_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> (!term_o || cycle_start_i));

  // R8
  ot_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ot_i) |=> core_rst_o);

  // R9
  term_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |-> !term_o);

  // R10
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (core_rst_o && ref_o == '0));
endmodule

bind softstart_seq softstart_seq_chk #(
  .CODE_W(CODE_W), .NOM_CODE(NOM_CODE), .RED_CODE(RED_CODE), .NOUT(NOUT)
) u_chk (.*);

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int NOM = 20;
  localparam int RED = 12;
  localparam int SD = 3;
  localparam int RC = 4;
  localparam int NO = 2;

  logic          clk, rst_n, en_i, vsel_i, cycle_start_i, ilim_i, ot_i, cool_i;
  logic [NO-1:0] uv_i;
  logic          core_rst_o, term_o;
  logic [CW-1:0] ref_o;
  int checks = 0;
  int fails = 0;

  softstart_seq #(.CODE_W(CW), .NOM_CODE(NOM), .RED_CODE(RED), .STEP_DIV(SD),
                  .RST_CYCLES(RC), .NOUT(NO)) i_softstart_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .vsel_i(vsel_i),
    .cycle_start_i(cycle_start_i), .ilim_i(ilim_i), .uv_i(uv_i), .ot_i(ot_i),
    .cool_i(cool_i), .core_rst_o(core_rst_o), .ref_o(ref_o), .term_o(term_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold cycles then release, from the negedge whose next edge enters reset
  task automatic wait_release(input int hold, input string tag);
    for (int i = 0; i < hold; i++) begin
      nedge(1);
      chk({tag, " reset held"}, core_rst_o, 1);
    end
    nedge(1);
    chk({tag, " reset released"}, core_rst_o, 0);
    chk({tag, " ref at release"}, ref_o, 0);
  endtask

  // origin: current negedge with step timer at zero
  task automatic ramp_check(input int start, input int target, input string tag);
    int d = (target > start) ? target - start : start - target;
    int s = (target > start) ? 1 : -1;
    for (int k = 1; k <= d; k++) begin
      nedge(SD - 1);
      chk({tag, " before step"}, ref_o, start + s*(k-1));
      nedge(1);
      chk({tag, " after step"}, ref_o, start + s*k);
      chk("R6 no reset while ramping", core_rst_o, 0);
      if (k == 2) uv_i = '0;
    end
    nedge(2*SD);
    chk({tag, " clamp at target"}, ref_o, target);
  endtask

  initial begin
    rst_n = 1'b0; en_i = 1'b0; vsel_i = 1'b1; cycle_start_i = 1'b0;
    ilim_i = 1'b0; uv_i = '0; ot_i = 1'b0; cool_i = 1'b0;
    nedge(3);
    chk("R1 reset core_rst", core_rst_o, 1);
    chk("R1 reset ref", ref_o, 0);
    chk("R1 reset term", term_o, 0);
    rst_n = 1'b1;
    nedge(2);
    chk("R1 disabled core_rst", core_rst_o, 1);

    // start-up sweep over both select levels
    for (int v = 0; v < 2; v++) begin
      en_i = 1'b0;
      nedge(2);
      vsel_i = v[0];
      en_i = 1'b1;
      wait_release(RC, "R2");
      ramp_check(0, v ? NOM : RED, "R3 ramp");
    end

    // select slews down then up, with undervoltage masked during slew
    vsel_i = 1'b0;
    ramp_check(NOM, RED, "R4 slew down");
    vsel_i = 1'b1;
    uv_i = 2'b01;
    ramp_check(RED, NOM, "R4 slew up");

    // short circuit while settled: reset and rerun ramp with flag still high
    uv_i = 2'b10;
    nedge(1);
    chk("R5 short reset", core_rst_o, 1);
    chk("R5 short ref", ref_o, 0);
    wait_release(RC - 1, "R5");
    ramp_check(0, NOM, "R5 re-ramp");

    // current limit: one pulse per switching cycle, no reset
    ilim_i = 1'b1;
    #1 chk("R7 term pulse", term_o, 1);
    nedge(1);
    chk("R7 second term blocked", term_o, 0);
    chk("R7 no reset", core_rst_o, 0);
    chk("R7 ref kept", ref_o, NOM);
    nedge(1);
    cycle_start_i = 1'b1;
    #1 chk("R7 new cycle term", term_o, 1);
    nedge(1);
    cycle_start_i = 1'b0;
    #1 chk("R7 term ends", term_o, 0);
    ilim_i = 1'b0;

    // thermal hold
    ot_i = 1'b1;
    nedge(1);
    chk("R8 thermal reset", core_rst_o, 1);
    ot_i = 1'b0;
    nedge(RC + 4);
    chk("R8 held without cool", core_rst_o, 1);
    cool_i = 1'b1;
    wait_release(RC, "R8");
    cool_i = 1'b0;
    ramp_check(0, NOM, "R8 re-ramp");

    // all three faults together
    ot_i = 1'b1; uv_i = 2'b11; ilim_i = 1'b1; cycle_start_i = 1'b1;
    #1 chk("R9 no term under thermal", term_o, 0);
    nedge(1);
    ot_i = 1'b0; uv_i = '0; ilim_i = 1'b0; cycle_start_i = 1'b0;
    chk("R9 reset", core_rst_o, 1);
    nedge(RC + 3);
    chk("R9 thermal hold wins", core_rst_o, 1);
    cool_i = 1'b1;
    wait_release(RC, "R9");
    cool_i = 1'b0;
    ramp_check(0, NOM, "R9 re-ramp");

    // disable overrides
    en_i = 1'b0;
    ilim_i = 1'b1;
    #1 chk("R10 no term when disabled", term_o, 0);
    nedge(1);
    chk("R10 disable reset", core_rst_o, 1);
    chk("R10 disable ref", ref_o, 0);
    chk("R10 term off", term_o, 0);
    ilim_i = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule